// File: doc/BRIEF.md
# Palettized FP8 Weight Dequantizer

This block expands compressed weight tensors. Software first fills a small codebook of 8-bit floating-point values (1 sign, 4 exponent, 3 mantissa bits, bias 7, no infinity) through a write port. A job is then started with an index width, an element count and a per-tensor half-precision scale. The block takes a packed stream of codebook indices as 32-bit words, unpacks one index per cycle, looks the index up, widens the looked-up code to fp16 and multiplies it by the scale. Each result goes out as one fp16 weight under a valid/ready handshake.

The mapping is symmetric only: every output is scale times code. A job that asks for a zero offset is refused. Indices of 3 and 6 bits are packed with no padding, so one index can straddle two input words. Any bits left over in the final word of a job are dropped.

Top module: `pal_dequant`

## Requirements
- R1: `cfg_width` selects the index width: code 0→1, 1→2, 2→3, 3→4, 4→6, 5→8 bits. Indices are packed least-significant-bit first and back to back across consecutive 32-bit words: bit j of index k is stream bit k*width+j, and stream bit i is bit i mod 32 of word i/32.
- R2: The codebook has 2^width usable entries, addressed by the unpacked index. A `cb_wr_en` write while the block is idle stores `cb_wr_data` at `cb_wr_addr`.
- R3: Codebook writes made while `busy` is high are ignored. Later outputs still use the entry as it was before the job.
- R4: Each output is the fp16 product of `cfg_scale` and the decoded code, rounded to nearest with ties to even. An exponent field of 0 in the code means a subnormal value m·2^-9. Results too large for fp16 become a signed infinity (0x7C00 magnitude), and results too small flush through fp16 subnormals to a signed zero.
- R5: A codebook code of 0x7F or 0xFF (exponent 1111, mantissa 111) gives the output 0x7E00 whatever the scale. A NaN scale, or an infinite scale times a zero code, also gives 0x7E00. An infinite scale times a nonzero code gives an infinity with the sign of the product.
- R6: A `start` pulse with a nonzero `cfg_zero_point` or a width code of 6 or 7 raises `cfg_err` for exactly one cycle, on the cycle after `start`. No job begins and no output is produced.
- R7: A valid `start` with count N produces exactly N outputs, in index order. `done` pulses for one cycle, on the cycle after the last output handshake. A count of 0 pulses `done` on the cycle after `start` and produces no output. Leftover bits of the final word do not carry into the next job.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. Backpressure neither drops nor repeats an element.
- R9: A job takes exactly ceil(N·width/32) input words. `in_ready` is low once those words are taken, and it is low whenever the block is idle.
- R10: After reset, `busy`, `out_valid`, `in_ready`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job using the cfg_* values |
| cfg_width | input | 3 | Index width code |
| cfg_count | input | 16 | Elements in the job |
| cfg_scale | input | 16 | fp16 per-tensor scale |
| cfg_zero_point | input | 8 | Requested zero offset; must be zero |
| cb_wr_en | input | 1 | Codebook write strobe |
| cb_wr_addr | input | 8 | Codebook entry address |
| cb_wr_data | input | 8 | 8-bit float code to store |
| in_valid | input | 1 | Packed index word valid |
| in_data | input | 32 | Packed index word |
| in_ready | output | 1 | Word accepted this cycle when valid |
| out_valid | output | 1 | Weight available |
| out_data | output | 16 | fp16 weight |
| out_ready | input | 1 | Consumer accepts the weight |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| cfg_err | output | 1 | One-cycle rejected-start pulse |

## Verification
The hardest case to reach is an index that straddles a word boundary arriving on the very cycle that output backpressure stalls the unpacker while a new word is being appended. Packing depends on width, and stalls come from two independent sources, so that case only shows up when both handshakes are toggled together. The stimulus therefore runs the 3- and 6-bit jobs with pseudo-random gaps on `in_valid` and pseudo-random drops of `out_ready`, and uses element counts that leave partial final words. An 8-bit job fills the codebook with all 256 codes to sweep every decode, and other jobs use overflowing, subnormal and infinite scales.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Width code to index width in bits; 0 marks an illegal code.
    function automatic logic [3:0] width_of(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd3;
            3'd3:    return 4'd4;
            3'd4:    return 4'd6;
            3'd5:    return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    // 8-bit float (bias 7, NaN only at all-ones) to fp16; exact.
    function automatic logic [15:0] fp8_to_half(input logic [7:0] c);
        logic       s;
        logic [3:0] e;
        logic [2:0] m;
        s = c[7];
        e = c[6:3];
        m = c[2:0];
        if (e == 4'hF && m == 3'h7) return 16'h7E00;
        if (e == 4'd0) begin
            case (m)
                3'd0:        return {s, 15'd0};
                3'd1:        return {s, 5'd6, 10'd0};
                3'd2, 3'd3:  return {s, 5'd7, m[0], 9'd0};
                default:     return {s, 5'd8, m[1:0], 8'd0};
            endcase
        end
        return {s, 5'({1'b0, e}) + 5'd8, m, 7'd0};
    endfunction

    // fp16 times fp16, round to nearest even, overflow to infinity.
    function automatic logic [15:0] half_mul(input logic [15:0] a, input logic [15:0] b);
        logic        s, a_nan, a_inf, a_zero, b_nan, b_inf, b_zero, g, st;
        logic [10:0] sa, sb;
        logic [63:0] p, kept, mask;
        int          ea, eb, lead, ex, sh, bits;
        s      = a[15] ^ b[15];
        a_nan  = (a[14:10] == 5'h1F) && (a[9:0] != 10'd0);
        a_inf  = (a[14:10] == 5'h1F) && (a[9:0] == 10'd0);
        a_zero = (a[14:0] == 15'd0);
        b_nan  = (b[14:10] == 5'h1F) && (b[9:0] != 10'd0);
        b_inf  = (b[14:10] == 5'h1F) && (b[9:0] == 10'd0);
        b_zero = (b[14:0] == 15'd0);
        if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero)) return 16'h7E00;
        if (a_inf || b_inf) return {s, 15'h7C00};
        if (a_zero || b_zero) return {s, 15'd0};
        sa = {a[14:10] != 5'd0, a[9:0]};
        sb = {b[14:10] != 5'd0, b[9:0]};
        ea = (a[14:10] == 5'd0) ? 1 : int'(a[14:10]);
        eb = (b[14:10] == 5'd0) ? 1 : int'(b[14:10]);
        p  = {53'd0, sa} * {53'd0, sb};
        lead = 0;
        for (int i = 0; i < 22; i++) if (p[i]) lead = i;
        ex = lead + ea + eb - 35;
        sh = (ex >= 1) ? lead - 10 : lead - 9 - ex;
        g  = 1'b0;
        st = 1'b0;
        mask = '0;
        if (sh <= 0) begin
            kept = p << (-sh);
        end else if (sh > 40) begin
            kept = '0;
            st   = 1'b1;
        end else begin
            kept = p >> sh;
            g    = p[sh-1];
            mask = (64'd1 << (sh - 1)) - 64'd1;
            st   = |(p & mask);
        end
        if (g && (st || kept[0])) kept = kept + 64'd1;
        bits = ((ex >= 1) ? ex - 1 : 0) * 1024 + int'(kept[11:0]);
        if (bits >= 32'h7C00) return {s, 15'h7C00};
        return {s, bits[14:0]};
    endfunction

endpackage

// File: rtl/pal_codebook.sv
module pal_codebook #(
    parameter int IDX_W = 8,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [CODE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CODE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pal_unpack.sv
module pal_unpack #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 8,
    parameter int NEED_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NEED_W-1:0] load_bits,
    input  logic [3:0]        width,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              idx_avail,
    output logic [IDX_W-1:0]  idx
);
    localparam int BUF_W  = 2 * WORD_W;
    localparam int FILL_W = $clog2(BUF_W) + 1;

    typedef struct packed {
        logic [BUF_W-1:0]  bits;
        logic [FILL_W-1:0] fill;
        logic [NEED_W-1:0] need;
    } unp_t;

    unp_t s_d, s_q;

    logic [FILL_W-1:0] wfill, cons, fmid;
    logic [BUF_W-1:0]  shifted;
    logic [IDX_W:0]    one_sh;
    logic [IDX_W-1:0]  mask;

    assign wfill     = FILL_W'(width);
    assign in_ready  = (s_q.need != '0) && (s_q.fill <= FILL_W'(WORD_W));
    assign idx_avail = s_q.fill >= wfill;
    assign one_sh    = (IDX_W + 1)'(1) << width;
    assign mask      = one_sh[IDX_W-1:0] - IDX_W'(1);
    assign idx       = s_q.bits[IDX_W-1:0] & mask;

    always_comb begin
        s_d     = s_q;
        cons    = take ? wfill : '0;
        shifted = s_q.bits >> cons;
        fmid    = s_q.fill - cons;
        if (load) begin
            s_d      = '0;
            s_d.need = load_bits;
        end else if (in_valid && in_ready) begin
            s_d.bits = shifted | ({{WORD_W{1'b0}}, in_data} << fmid);
            s_d.fill = fmid + FILL_W'(WORD_W);
            s_d.need = (s_q.need > NEED_W'(WORD_W)) ? s_q.need - NEED_W'(WORD_W) : '0;
        end else begin
            s_d.bits = shifted;
            s_d.fill = fmid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // An index is only consumed when enough bits are buffered.
    p_take_avail_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> idx_avail);

    // A new job starts from an empty buffer: leftovers are gone.
    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !idx_avail);
endmodule

// File: rtl/pal_dequant.sv
module pal_dequant #(
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cfg_width,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [15:0]       cfg_scale,
    input  logic [7:0]        cfg_zero_point,
    input  logic              cb_wr_en,
    input  logic [IDX_W-1:0]  cb_wr_addr,
    input  logic [7:0]        cb_wr_data,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [15:0]       out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    import pal_pkg::*;

    localparam int NEED_W = CNT_W + $clog2(IDX_W) + 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
        logic [2:0]       wcode;
        logic [15:0]      scale;
        logic             ov;
        logic [15:0]      od;
        logic             olast;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              load, issue, idx_avail;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        cb_rd;
    logic [NEED_W-1:0] load_bits;
    logic [3:0]        wval;

    assign wval      = width_of(c_q.wcode);
    assign load_bits = NEED_W'(width_of(cfg_width)) * NEED_W'(cfg_count);
    assign issue     = c_q.busy && (c_q.left != '0) && idx_avail && (!c_q.ov || out_ready);

    pal_unpack #(.WORD_W(WORD_W), .IDX_W(IDX_W), .NEED_W(NEED_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_bits (load_bits),
        .width     (wval),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .take      (issue),
        .idx_avail (idx_avail),
        .idx       (idx)
    );

    pal_codebook #(.IDX_W(IDX_W), .CODE_W(8)) u_cb (
        .clk     (clk),
        .wr_en   (cb_wr_en && !c_q.busy),
        .wr_addr (cb_wr_addr),
        .wr_data (cb_wr_data),
        .rd_addr (idx),
        .rd_data (cb_rd)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.err  = 1'b0;
        load     = 1'b0;
        if (c_q.ov && out_ready) c_d.ov = 1'b0;
        if (issue) begin
            c_d.ov    = 1'b1;
            c_d.od    = half_mul(c_q.scale, fp8_to_half(cb_rd));
            c_d.olast = (c_q.left == CNT_W'(1));
            c_d.left  = c_q.left - CNT_W'(1);
        end
        if (c_q.ov && out_ready && c_q.olast) begin
            c_d.done  = 1'b1;
            c_d.busy  = 1'b0;
            c_d.olast = 1'b0;
        end
        if (start && !c_q.busy) begin
            if (cfg_zero_point != 8'd0 || width_of(cfg_width) == 4'd0) begin
                c_d.err = 1'b1;
            end else if (cfg_count == '0) begin
                c_d.done = 1'b1;
            end else begin
                c_d.busy  = 1'b1;
                c_d.left  = cfg_count;
                c_d.wcode = cfg_width;
                c_d.scale = cfg_scale;
                load      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign out_valid = c_q.ov;
    assign out_data  = c_q.od;
    assign busy      = c_q.busy;
    assign done      = c_q.done;
    assign cfg_err   = c_q.err;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_nan_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (cb_rd[6:0] == 7'h7F) |=> out_data == 16'h7E00);

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy && !out_valid);

    p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !out_valid);
endmodule

// File: tb/pal_dequant_test.sv
module pal_dequant_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cfg_width = 3'd0;
    logic [15:0] cfg_count = 16'd0;
    logic [15:0] cfg_scale = 16'd0;
    logic [7:0]  cfg_zero_point = 8'd0;
    logic        cb_wr_en = 1'b0;
    logic [7:0]  cb_wr_addr = 8'd0;
    logic [7:0]  cb_wr_data = 8'd0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = 32'd0;
    logic        in_ready, out_valid, busy, done, cfg_err;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0]  cb_m   [256];
    int          idxs   [1024];
    logic [31:0] words  [128];
    logic [15:0] expv   [1024];

    always #2 clk = ~clk;

    pal_dequant uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
        .cfg_count(cfg_count), .cfg_scale(cfg_scale), .cfg_zero_point(cfg_zero_point),
        .cb_wr_en(cb_wr_en), .cb_wr_addr(cb_wr_addr), .cb_wr_data(cb_wr_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int wbits(input int code);
        case (code)
            0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 6; default: return 8;
        endcase
    endfunction

    function automatic real pow2(input int e);
        return 2.0 ** e;
    endfunction

    function automatic real half_val(input logic [15:0] h);
        if (h[14:10] == 5'd0) return real'(h[9:0]) * pow2(-24);
        return real'(1024 + h[9:0]) * pow2(int'(h[14:10]) - 25);
    endfunction

    function automatic real fp8_val(input logic [7:0] c);
        if (c[6:3] == 4'd0) return real'(c[2:0]) * pow2(-9);
        return (1.0 + real'(c[2:0]) / 8.0) * pow2(int'(c[6:3]) - 7);
    endfunction

    // Expected weight from the arithmetic definition (R4, R5).
    function automatic logic [15:0] expect_out(input logic [15:0] sc, input logic [7:0] c);
        logic s;
        real  a, q, fl, fr;
        int   e, bits, m;
        s = sc[15] ^ c[7];
        if (c[6:0] == 7'h7F) return 16'h7E00;
        if (sc[14:10] == 5'h1F && sc[9:0] != 0) return 16'h7E00;
        if (sc[14:10] == 5'h1F) begin
            if (c[6:0] == 7'd0) return 16'h7E00;
            return {s, 15'h7C00};
        end
        a = half_val(sc) * fp8_val(c);
        if (a == 0.0) return {s, 15'd0};
        e = -60;
        while (pow2(e + 1) <= a) e++;
        if (e < -14) q = a * pow2(24);
        else         q = a * pow2(10 - e);
        fl = $floor(q);
        fr = q - fl;
        m  = int'(fl);
        if (fr > 0.5 || (fr == 0.5 && (m % 2) == 1)) m++;
        if (e < -14) bits = m;
        else         bits = (e + 14) * 1024 + m;
        if (bits >= 'h7C00) return {s, 15'h7C00};
        return {s, bits[14:0]};
    endfunction

    task automatic load_cb(input int code, input bool_all);
        int w = wbits(code);
        for (int i = 0; i < (1 << w); i++) begin
            if (bool_all != 0) cb_m[i] = 8'(i);
            else               cb_m[i] = 8'((i * 73 + code * 29 + 11) & 255);
        end
        if (bool_all == 0) cb_m[(1 << w) - 1] = 8'h7F;
        for (int i = 0; i < (1 << w); i++) begin
            @(negedge clk);
            cb_wr_en   = 1'b1;
            cb_wr_addr = 8'(i);
            cb_wr_data = cb_m[i];
        end
        @(negedge clk);
        cb_wr_en = 1'b0;
    endtask

    task automatic run_job(input int code, input int n, input logic [15:0] sc,
                           input int ofs, input bit rnd, input bit poke);
        int w = wbits(code);
        int nw, wp, op, iter, pos;
        bit pend, poked, hold_v;
        logic [15:0] hold_d;
        string tag;
        nw = (n * w + 31) / 32;
        for (int i = 0; i < 128; i++) words[i] = 32'd0;
        pos = 0;
        for (int k = 0; k < n; k++) begin
            idxs[k] = (k * 5 + ofs) % (1 << w);
            expv[k] = expect_out(sc, cb_m[idxs[k]]);
            for (int j = 0; j < w; j++) begin
                words[pos / 32][pos % 32] = idxs[k][j];
                pos++;
            end
        end
        @(negedge clk);
        cfg_width = 3'(code); cfg_count = 16'(n); cfg_scale = sc; cfg_zero_point = 8'd0;
        start = 1'b1;
        wp = 0; op = 0; iter = 0; pend = 0; poked = 0; hold_v = 0; hold_d = 16'd0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            cb_wr_en = 1'b0;
            iter++;
            if (pend) begin
                chk(done == 1'b1, "R7 done one cycle after last output", done, 1);
                break;
            end
            if (done) chk(1'b0, "R7 done before last output", op, n);
            if (iter > 20000) begin
                chk(1'b0, "R7 job hung", op, n);
                break;
            end
            if (hold_v) chk(out_valid && out_data == hold_d, "R8 held output", out_data, hold_d);
            in_valid  = (wp < nw) && (!rnd || lfsr[0] || lfsr[3]);
            in_data   = words[(wp < nw) ? wp : 0];
            out_ready = !rnd || (lfsr[5:4] != 2'b00);
            if (poke && !poked && op == 3) begin
                cb_wr_en   = 1'b1;
                cb_wr_addr = 8'(idxs[n-1]);
                cb_wr_data = ~cb_m[idxs[n-1]];
                poked = 1;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (in_valid && in_ready) wp++;
            hold_v = out_valid && !out_ready;
            hold_d = out_data;
            if (out_valid && out_ready) begin
                if (cb_m[idxs[op]][6:0] == 7'h7F) tag = "R5 NaN code";
                else if (poked && idxs[op] == idxs[n-1]) tag = "R3 busy write ignored";
                else tag = "R4/R1/R2 weight";
                chk(out_data == expv[op], $sformatf("%s w=%0d k=%0d", tag, w, op), out_data, expv[op]);
                op++;
                if (op == n) pend = 1;
            end
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        chk(wp == nw, "R9 word count", wp, nw);
        chk(in_ready == 1'b0, "R9 in_ready low after job", in_ready, 0);
        chk(out_valid == 1'b0 && busy == 1'b0, "R7 idle after done", {out_valid, busy}, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done is one cycle", done, 0);
    endtask

    task automatic bad_start(input logic [2:0] code, input logic [7:0] zp, input string what);
        @(negedge clk);
        cfg_width = code; cfg_count = 16'd8; cfg_scale = 16'h3C00; cfg_zero_point = zp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_zero_point = 8'd0;
        chk(cfg_err == 1'b1, {"R6 error pulse ", what}, cfg_err, 1);
        chk(busy == 1'b0, {"R6 no job ", what}, busy, 0);
        @(negedge clk);
        chk(cfg_err == 1'b0 && out_valid == 1'b0 && in_ready == 1'b0,
            {"R6 single pulse, no output ", what}, {cfg_err, out_valid, in_ready}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, out_valid, in_ready, done, cfg_err} == 5'd0, "R10 state in reset",
            {busy, out_valid, in_ready, done, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, out_valid, in_ready, done, cfg_err} == 5'd0, "R10 state after reset",
            {busy, out_valid, in_ready, done, cfg_err}, 0);

        load_cb(5, 1);
        run_job(5, 263, 16'h3C00, 0, 1'b0, 1'b0);
        run_job(5, 20, 16'h7C00, 0, 1'b1, 1'b0);
        load_cb(2, 0);
        run_job(2, 101, 16'hC500, 1, 1'b1, 1'b1);
        run_job(2, 13, 16'h3C00, 2, 1'b1, 1'b0);
        load_cb(4, 0);
        run_job(4, 77, 16'h3555, 3, 1'b1, 1'b0);
        load_cb(0, 0);
        run_job(0, 70, 16'h1400, 1, 1'b1, 1'b0);
        load_cb(1, 0);
        run_job(1, 45, 16'h7800, 2, 1'b1, 1'b0);
        load_cb(3, 0);
        run_job(3, 33, 16'h0001, 5, 1'b1, 1'b0);
        run_job(3, 17, 16'hFE00, 0, 1'b0, 1'b0);

        bad_start(3'd2, 8'd3, "zero point");
        bad_start(3'd6, 8'd0, "width code 6");
        bad_start(3'd7, 8'd0, "width code 7");

        @(negedge clk);
        cfg_width = 3'd1; cfg_count = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R7 zero count done", {done, busy}, 2);
        @(negedge clk);
        chk(done == 1'b0 && out_valid == 1'b0, "R7 zero count no output", {done, out_valid}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule